// File: doc/BRIEF.md
# Descriptor Ring Prefetch and Writeback Cache

This block keeps a small on-chip cache of DMA descriptors for a single ring in host memory. The ring is described by a base address, a length in bytes and a producer tail. The block owns the head and a fetch pointer. On request, it reads a burst of descriptors into the cache, never past the tail, never past the end of the ring and never beyond the free cache slots. It offers the cached descriptors one at a time to a consumer and collects the ones the consumer returns as finished. On a writeback request, it writes the finished ones back to memory in a burst and advances the head when that write completes.

The descriptor contents do not pass through the block. Each cache class (unused, held by the consumer, finished) is a count, and each DMA request carries only an address and a descriptor count. A writeback is trimmed to a caller-supplied alignment mask. A writeback that would pass the ring end is cut at the end and continued after the wrap. A less restrictive request that arrives while a writeback is outstanding is remembered and run once that writeback completes. Both directions wait a programmable number of cycles between choosing a transfer and raising the request.

Top module: `desc_ring_cache`

## Requirements
- R1: After reset no DMA request is raised, `ring_head` and `fetch_ptr` are 0 and `take_valid` is low.
- R2: The ring holds `ring_bytes >> 4` descriptors. A fetch asks for `ring_tail - fetch_ptr` when the tail is at or ahead of the fetch pointer, and otherwise for the ring length minus the fetch pointer, so a read burst never crosses the ring end.
- R3: The fetch count is limited to the free slots, which are CAP minus the unused, held and finished descriptors. When the result is zero, no request is raised.
- R4: At most one read is outstanding. A `fetch_req` seen while a fetch is being prepared or is in flight is ignored.
- R5: When `dma_rd_done` arrives, the fetched descriptors become available through `take_valid`. `fetch_ptr` advances by the count and wraps to 0 at the ring length.
- R6: If head plus the finished count reaches or passes the ring length, the writeback count is the ring length minus head, without masking. A follow-up writeback then runs after completion with the stored mask.
- R7: Otherwise the writeback count is the finished count AND NOT the mask. A zero count raises no request.
- R8: A `wb_req` arriving while a writeback is pending, with a mask numerically smaller than the stored one, replaces the stored mask and causes one further writeback with it after completion. A request whose mask is not smaller has no effect.
- R9: On `dma_wr_done`, `ring_head` advances by the written count and wraps to 0 at the ring length. The finished count drops by the same amount.
- R10: A request is raised exactly delay+1 cycles after the clock edge that samples the triggering request (`fetch_dly` or `wb_dly`).
- R11: The request address is `ring_base + index*16`, where the index is `fetch_ptr` for reads and `ring_head` for writes. `dma_req_wr` is 1 for writes.
- R12: A raised request keeps its kind, address and count until `dma_req_ready`. When a read and a write become ready in the same cycle, the write is presented first.
- R13: `take_ready` with `take_valid` moves one descriptor from unused to held. `ret_valid` moves one held descriptor to finished and is ignored when none is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | ADDR_W | Ring base byte address |
| ring_bytes | input | IDX_W+4 | Ring length in bytes |
| ring_tail | input | IDX_W | Producer tail index |
| ring_head | output | IDX_W | Head index, advanced by writebacks |
| fetch_ptr | output | IDX_W | Next ring index to fetch |
| fetch_dly | input | DLY_W | Cycles between fetch decision and request |
| wb_dly | input | DLY_W | Cycles between writeback decision and request |
| fetch_req | input | 1 | Request a descriptor fetch |
| wb_req | input | 1 | Request a writeback |
| wb_mask | input | CNT_W | Alignment mask for the writeback |
| take_valid | output | 1 | An unused descriptor is available |
| take_ready | input | 1 | Consumer takes one descriptor |
| ret_valid | input | 1 | Consumer returns one finished descriptor |
| dma_req_valid | output | 1 | DMA request raised |
| dma_req_ready | input | 1 | DMA request accepted |
| dma_req_wr | output | 1 | 1 = writeback, 0 = fetch |
| dma_req_addr | output | ADDR_W | Burst byte address |
| dma_req_cnt | output | CNT_W | Descriptors in the burst |
| dma_rd_done | input | 1 | Outstanding fetch completed |
| dma_wr_done | input | 1 | Outstanding writeback completed |

## Verification
The read and write paths share one request channel, so both can ask for it in the same cycle. The bench gives both paths the same delay, pulses `fetch_req` and `wb_req` on the same edge and holds `dma_req_ready` low for several cycles. It then checks that the write is presented first and holds its address and count, and that the read follows with its own count and address once the write has been accepted. A second overlap comes from pulsing a new `wb_req` or `fetch_req` while the same direction is in flight. This one is judged from the requests seen after completion.

// File: rtl/desc_ring_cache.sv
module desc_ring_cache #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16,
  parameter int CAP    = 8,
  parameter int DLY_W  = 8,
  localparam int CNT_W = $clog2(CAP + 1),
  localparam int LEN_W = IDX_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [LEN_W-1:0]  ring_bytes,
  input  logic [IDX_W-1:0]  ring_tail,
  output logic [IDX_W-1:0]  ring_head,
  output logic [IDX_W-1:0]  fetch_ptr,
  input  logic [DLY_W-1:0]  fetch_dly,
  input  logic [DLY_W-1:0]  wb_dly,
  input  logic              fetch_req,
  input  logic              wb_req,
  input  logic [CNT_W-1:0]  wb_mask,
  output logic              take_valid,
  input  logic              take_ready,
  input  logic              ret_valid,
  output logic              dma_req_valid,
  input  logic              dma_req_ready,
  output logic              dma_req_wr,
  output logic [ADDR_W-1:0] dma_req_addr,
  output logic [CNT_W-1:0]  dma_req_cnt,
  input  logic              dma_rd_done,
  input  logic              dma_wr_done
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_REQ, S_BUSY} st_t;

  st_t fst, wst;
  logic [CNT_W-1:0] n_unused, n_held, n_used;
  logic [CNT_W-1:0] fcnt, wcnt, wmask;
  logic [DLY_W-1:0] fdc, wdc;
  logic more, replay, hold_rd;

  logic [IDX_W-1:0] len;
  logic [IDX_W-1:0] f_avail;
  logic [CNT_W:0]   occ;
  logic [CNT_W-1:0] f_free, f_take;
  logic             f_go;

  assign len     = ring_bytes[LEN_W-1:4];
  assign f_avail = (ring_tail >= fetch_ptr) ? ring_tail - fetch_ptr : len - fetch_ptr;
  assign occ     = (CNT_W+1)'(n_unused) + (CNT_W+1)'(n_held) + (CNT_W+1)'(n_used);
  assign f_free  = CNT_W'((CNT_W+1)'(CAP) - occ);
  assign f_take  = (f_avail < IDX_W'(f_free)) ? CNT_W'(f_avail) : f_free;
  assign f_go    = (fst == S_IDLE) && fetch_req && (f_take != '0);

  logic [CNT_W-1:0] w_msk, w_take;
  logic [IDX_W:0]   w_end;
  logic             w_go, w_split, w_late;

  assign w_go    = (wst == S_IDLE) && (wb_req || replay);
  assign w_msk   = wb_req ? wb_mask : wmask;
  assign w_end   = {1'b0, ring_head} + (IDX_W+1)'(n_used);
  assign w_split = w_end >= {1'b0, len};
  assign w_take  = w_split ? CNT_W'(len - ring_head) : (n_used & ~w_msk);
  assign w_late  = (wst != S_IDLE) && wb_req && (wb_mask < wmask);

  logic wreq, rreq, acc_r, acc_w, rd_fin, wr_fin, take_fire, ret_fire;
  assign wreq          = (wst == S_REQ);
  assign rreq          = (fst == S_REQ);
  assign dma_req_valid = wreq || rreq;
  assign dma_req_wr    = wreq && !hold_rd;
  assign dma_req_cnt   = dma_req_wr ? wcnt : fcnt;
  assign dma_req_addr  = ring_base + ADDR_W'({(dma_req_wr ? ring_head : fetch_ptr), 4'b0000});
  assign acc_r         = dma_req_valid && dma_req_ready && !dma_req_wr;
  assign acc_w         = dma_req_valid && dma_req_ready && dma_req_wr;
  assign rd_fin        = dma_rd_done && (fst == S_BUSY);
  assign wr_fin        = dma_wr_done && (wst == S_BUSY);
  assign take_valid    = (n_unused != '0);
  assign take_fire     = take_valid && take_ready;
  assign ret_fire      = ret_valid && (n_held != '0);

  logic [IDX_W:0] f_nx, h_nx;
  assign f_nx = {1'b0, fetch_ptr} + (IDX_W+1)'(fcnt);
  assign h_nx = {1'b0, ring_head} + (IDX_W+1)'(wcnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_unused <= '0;
      n_held   <= '0;
      n_used   <= '0;
      hold_rd  <= 1'b0;
    end else begin
      n_unused <= n_unused + (rd_fin ? fcnt : '0) - CNT_W'(take_fire);
      n_held   <= n_held + CNT_W'(take_fire) - CNT_W'(ret_fire);
      n_used   <= n_used + CNT_W'(ret_fire) - (wr_fin ? wcnt : '0);
      hold_rd  <= dma_req_valid && !dma_req_wr && !dma_req_ready;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fst       <= S_IDLE;
      fcnt      <= '0;
      fdc       <= '0;
      fetch_ptr <= '0;
    end else begin
      case (fst)
        S_IDLE: if (f_go) begin
          fcnt <= f_take;
          fdc  <= fetch_dly;
          fst  <= S_WAIT;
        end
        S_WAIT: if (fdc == '0) fst <= S_REQ; else fdc <= fdc - 1'b1;
        S_REQ:  if (acc_r) fst <= S_BUSY;
        S_BUSY: if (dma_rd_done) begin
          fst       <= S_IDLE;
          fetch_ptr <= (f_nx >= {1'b0, len}) ? IDX_W'(f_nx - {1'b0, len}) : IDX_W'(f_nx);
        end
        default: fst <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wst       <= S_IDLE;
      wcnt      <= '0;
      wdc       <= '0;
      wmask     <= '0;
      more      <= 1'b0;
      replay    <= 1'b0;
      ring_head <= '0;
    end else begin
      if (w_late) begin
        wmask <= wb_mask;
        more  <= 1'b1;
      end
      case (wst)
        S_IDLE: if (w_go) begin
          replay <= 1'b0;
          wmask  <= w_msk;
          if (w_take != '0) begin
            wcnt <= w_take;
            wdc  <= wb_dly;
            more <= w_split;
            wst  <= S_WAIT;
          end
        end
        S_WAIT: if (wdc == '0) wst <= S_REQ; else wdc <= wdc - 1'b1;
        S_REQ:  if (acc_w) wst <= S_BUSY;
        S_BUSY: if (dma_wr_done) begin
          wst       <= S_IDLE;
          replay    <= more || w_late;
          more      <= 1'b0;
          ring_head <= (h_nx >= {1'b0, len}) ? IDX_W'(h_nx - {1'b0, len}) : IDX_W'(h_nx);
        end
        default: wst <= S_IDLE;
      endcase
    end
  end

  a_r2_fetch_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_valid && !dma_req_wr) |-> ({1'b0, fetch_ptr} + (IDX_W+1)'(dma_req_cnt) <= {1'b0, len}));

  a_r3_fetch_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_valid && !dma_req_wr) |->
      (dma_req_cnt != '0) && ((CNT_W+1)'(dma_req_cnt) + occ <= (CNT_W+1)'(CAP)));

  a_r4_one_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    acc_r |=> !(dma_req_valid && !dma_req_wr));

  a_r6_wb_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_valid && dma_req_wr) |-> ({1'b0, ring_head} + (IDX_W+1)'(dma_req_cnt) <= {1'b0, len}));

  a_r7_wb_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_valid && dma_req_wr && !more) |-> ((dma_req_cnt & wmask) == '0));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_valid && !dma_req_ready) |=>
      dma_req_valid && $stable(dma_req_wr) && $stable(dma_req_addr) && $stable(dma_req_cnt));

  a_r13_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (CNT_W+1)'(CAP));

endmodule

// File: tb/desc_ring_cache_tb_top.sv
`timescale 1ns/1ps
module desc_ring_cache_tb_top;
  localparam int ADDR_W = 32, IDX_W = 16, CAP = 8, DLY_W = 8;
  localparam int CNT_W = $clog2(CAP + 1);
  localparam int LEN = 16;
  localparam logic [31:0] BASE = 32'h1000_0000;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [ADDR_W-1:0] ring_base = BASE;
  logic [IDX_W+3:0]  ring_bytes = (IDX_W+4)'(LEN * 16);
  logic [IDX_W-1:0]  ring_tail = '0;
  logic [IDX_W-1:0]  ring_head, fetch_ptr;
  logic [DLY_W-1:0]  fetch_dly = '0, wb_dly = '0;
  logic fetch_req = 0, wb_req = 0, take_ready = 0, ret_valid = 0;
  logic [CNT_W-1:0]  wb_mask = '0;
  logic take_valid, dma_req_valid, dma_req_wr;
  logic dma_req_ready = 0, dma_rd_done = 0, dma_wr_done = 0;
  logic [ADDR_W-1:0] dma_req_addr;
  logic [CNT_W-1:0]  dma_req_cnt;

  desc_ring_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CAP(CAP), .DLY_W(DLY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_bytes(ring_bytes),
    .ring_tail(ring_tail), .ring_head(ring_head), .fetch_ptr(fetch_ptr),
    .fetch_dly(fetch_dly), .wb_dly(wb_dly), .fetch_req(fetch_req), .wb_req(wb_req),
    .wb_mask(wb_mask), .take_valid(take_valid), .take_ready(take_ready),
    .ret_valid(ret_valid), .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready),
    .dma_req_wr(dma_req_wr), .dma_req_addr(dma_req_addr), .dma_req_cnt(dma_req_cnt),
    .dma_rd_done(dma_rd_done), .dma_wr_done(dma_wr_done));

  int n_cmp = 0, n_bad = 0;
  bit done_flag = 0;
  int m_head = 0, m_fptr = 0, m_unused = 0, m_held = 0, m_used = 0, m_tail = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic int exp_fetch();
    int avail, free;
    avail = (m_tail >= m_fptr) ? m_tail - m_fptr : LEN - m_fptr;
    free = CAP - m_unused - m_held - m_used;
    return (avail < free) ? avail : free;
  endfunction

  function automatic int exp_wb(int mask);
    if (m_head + m_used >= LEN) return LEN - m_head;
    return m_used & ~mask;
  endfunction

  task automatic wait_req(output int k, output bit wr, output longint addr, output int cnt);
    k = -1; wr = 0; addr = 0; cnt = 0;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      if (dma_req_valid) begin
        k = i; wr = dma_req_wr; addr = dma_req_addr; cnt = int'(dma_req_cnt);
        dma_req_ready = 1;
        @(negedge clk);
        dma_req_ready = 0;
        return;
      end
    end
  endtask

  task automatic expect_none(string tag, int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (dma_req_valid) seen = 1;
    end
    chk(tag, seen, 0);
  endtask

  task automatic pulse_fetch();
    @(negedge clk); ring_tail = IDX_W'(m_tail); fetch_req = 1;
    @(negedge clk); fetch_req = 0;
  endtask

  task automatic pulse_wb(int mask);
    @(negedge clk); wb_mask = CNT_W'(mask); wb_req = 1;
    @(negedge clk); wb_req = 0;
  endtask

  task automatic done_rd();
    @(negedge clk); dma_rd_done = 1;
    @(negedge clk); dma_rd_done = 0;
  endtask

  task automatic done_wr();
    @(negedge clk); dma_wr_done = 1;
    @(negedge clk); dma_wr_done = 0;
  endtask

  task automatic do_fetch(int dly);
    int e, k, cnt; bit wr; longint addr;
    fetch_dly = DLY_W'(dly);
    e = exp_fetch();
    pulse_fetch();
    if (e == 0) begin
      expect_none("R3 zero fetch", 2 * dly + 8);
      return;
    end
    wait_req(k, wr, addr, cnt);
    chk("R10 fetch delay", k, dly + 1);
    chk("R11 fetch kind", wr, 0);
    chk("R2 fetch count", cnt, e);
    chk("R11 fetch addr", addr, BASE + m_fptr * 16);
    done_rd();
    m_unused += e;
    m_fptr = (m_fptr + e) % LEN;
    @(negedge clk);
    chk("R5 fetch_ptr", fetch_ptr, m_fptr);
    chk("R5 take_valid", take_valid, m_unused != 0);
  endtask

  task automatic take_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R13 take_valid", take_valid, m_unused != 0);
      take_ready = 1;
      @(negedge clk); take_ready = 0;
      if (m_unused > 0) begin m_unused--; m_held++; end
    end
  endtask

  task automatic ret_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ret_valid = 1;
      @(negedge clk); ret_valid = 0;
      if (m_held > 0) begin m_held--; m_used++; end
    end
  endtask

  task automatic do_wb(int mask, int dly);
    int e, k, cnt; bit wr, sp, first; longint addr;
    wb_dly = DLY_W'(dly);
    first = 1;
    forever begin
      e = exp_wb(mask);
      sp = (m_head + m_used >= LEN);
      if (first) pulse_wb(mask);
      if (e == 0) begin
        expect_none(first ? "R7 zero writeback" : "R6 empty follow-up", 2 * dly + 8);
        return;
      end
      wait_req(k, wr, addr, cnt);
      if (first) chk("R10 wb delay", k, dly + 1);
      chk("R11 wb kind", wr, 1);
      chk(sp ? "R6 split count" : "R7 aligned count", cnt, e);
      chk("R11 wb addr", addr, BASE + m_head * 16);
      done_wr();
      m_head = (m_head + e) % LEN;
      m_used -= e;
      @(negedge clk);
      chk("R9 head", ring_head, m_head);
      if (!sp) return;
      first = 0;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    int k, cnt, op; bit wr; longint addr;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid", dma_req_valid, 0);
    chk("R1 head", ring_head, 0);
    chk("R1 fetch_ptr", fetch_ptr, 0);
    chk("R1 take_valid", take_valid, 0);

    m_tail = 5;  do_fetch(3);
    m_tail = 14; do_fetch(0);
    do_fetch(1);
    take_n(8); ret_n(6);
    do_wb(3, 0);
    ret_n(3);
    do_wb(0, 2);

    m_tail = 14; do_fetch(1);
    m_tail = 3;  do_fetch(0);
    take_n(8); ret_n(8);
    do_wb(3, 1);

    m_tail = 3; do_fetch(0);
    take_n(3); ret_n(3);
    wb_dly = 1;
    pulse_wb(1);
    wait_req(k, wr, addr, cnt);
    chk("R7 masked count", cnt, 2);
    pulse_wb(3);
    done_wr();
    m_head = 2; m_used = 1;
    expect_none("R8 larger mask ignored", 10);
    chk("R9 head after mask", ring_head, 2);

    m_tail = 8; do_fetch(0);
    take_n(5); ret_n(5);
    pulse_wb(3);
    wait_req(k, wr, addr, cnt);
    chk("R7 masked count 2", cnt, 4);
    pulse_wb(0);
    done_wr();
    m_head = 6; m_used = 2;
    wait_req(k, wr, addr, cnt);
    chk("R8 replay count", cnt, 2);
    chk("R8 replay addr", addr, BASE + 6 * 16);
    done_wr();
    m_head = 8; m_used = 0;
    @(negedge clk);
    chk("R9 head after replay", ring_head, 8);

    m_tail = 12;
    fetch_dly = 0;
    pulse_fetch();
    wait_req(k, wr, addr, cnt);
    chk("R4 first fetch count", cnt, 4);
    m_tail = 14;
    pulse_fetch();
    expect_none("R4 fetch while busy", 10);
    done_rd();
    m_unused += 4; m_fptr = 12;
    m_tail = 14; do_fetch(0);

    m_tail = 1;
    take_n(2); ret_n(2);
    fetch_dly = 1; wb_dly = 1;
    @(negedge clk); ring_tail = IDX_W'(m_tail); wb_mask = '0; fetch_req = 1; wb_req = 1;
    @(negedge clk); fetch_req = 0; wb_req = 0;
    k = 0;
    while (!dma_req_valid && k < 20) begin @(negedge clk); k++; end
    chk("R12 write first", dma_req_wr, 1);
    chk("R12 write count", dma_req_cnt, 2);
    addr = dma_req_addr;
    repeat (3) begin
      @(negedge clk);
      chk("R12 held addr", dma_req_addr, addr);
    end
    chk("R12 held kind", dma_req_wr, 1);
    dma_req_ready = 1;
    @(negedge clk); dma_req_ready = 0;
    wait_req(k, wr, addr, cnt);
    chk("R12 read after write", wr, 0);
    chk("R12 read count", cnt, 2);
    chk("R12 read addr", addr, BASE + 14 * 16);
    done_wr(); done_rd();
    m_head = 10; m_used = 0; m_unused += 2; m_fptr = 0;
    @(negedge clk);
    chk("R9 head after overlap", ring_head, 10);
    chk("R5 fetch_ptr wrap", fetch_ptr, 0);

    for (int it = 0; it < 200; it++) begin
      op = int'($urandom % 4);
      case (op)
        0: begin m_tail = int'($urandom % LEN); do_fetch(int'($urandom % 4)); end
        1: take_n(int'($urandom % 4));
        2: ret_n(int'($urandom % 4));
        default: begin
          case ($urandom % 4)
            0: do_wb(0, int'($urandom % 3));
            1: do_wb(1, int'($urandom % 3));
            2: do_wb(3, int'($urandom % 3));
            default: do_wb(7, int'($urandom % 3));
          endcase
        end
      endcase
    end
    @(negedge clk);
    chk("R9 final head", ring_head, m_head);
    chk("R5 final fetch_ptr", fetch_ptr, m_fptr);
    finish_up();
  end
endmodule